// File: doc/BRIEF.md
# Block-Transfer Mailbox Registers

This block is the byte-wide register face of a two-way mailbox between a host processor and a management controller. The host sees three byte registers: a control/status byte holding attention and busy flags, a data port that streams bytes into a request buffer on writes and out of a response buffer on reads, and an interrupt byte. Each buffer has one pointer per side. The pointer steps by one on every access and wraps at the buffer depth.

The control byte uses action semantics instead of plain storage. Attention flags posted by the controller clear when the host writes a 1 to them. The host busy flag flips when the host writes a 1 to it. The request-ready flag is set by the host and cleared only by the controller. The two pointer-clear bits act as strobes and always read as zero. Zeros in any write leave the matching bits alone, so a host can touch one flag without a read-modify-write. A host that needs a definite busy level reads the bit first and writes a 1 only when the bit differs. A host may start a new request only when both controller busy and request-ready read as 0.

On the controller side, one-cycle pulses set or clear the controller's flags, read the request buffer and fill the response buffer. When the controller posts a response, the block raises a pending bit, which drives the host interrupt when it is enabled.

Top module: `bt_mbox_regs`

## Requirements
- R1: After reset, the control byte, the interrupt byte, `ctl_flags`, `host_irq` and `ctl_hw_reset` all read 0, and every buffer pointer is 0.
- R2: `host_addr` 0 reads the control byte, 1 reads the response byte at the host read pointer, 2 reads the interrupt byte, and 3 reads 0. The control byte layout is bit7 controller busy, bit6 host busy, bit5 OEM flag, bit4 SMS attention, bit3 response attention, bit2 request attention, with bits 1:0 reading 0.
- R3: A host write to offset 0 with bit6 = 1 inverts host busy. With bit6 = 0 it leaves host busy unchanged.
- R4: A host write of 1 to control bit3, bit4 or bit5 clears that flag, and a 0 leaves it unchanged. Host writes never change bit7.
- R5: A host write of 1 to control bit2 sets request attention, and a 0 has no effect. Only `ctl_clr_h2b_atn` clears it.
- R6: A host write of 1 to control bit0 returns the request write pointer to 0, and a 1 to bit1 returns the response read pointer to 0, in the same clock edge. `ctl_ptr_clr` returns both controller-side pointers to 0.
- R7: Host writes to offset 1 fill the request buffer in order. The controller reads the bytes back in the same order on `ctl_req_rdata`, and each `ctl_req_rd_en` steps to the next byte.
- R8: `ctl_rsp_wr_en` fills the response buffer in order. Each host read of offset 1 returns the current byte and steps to the next.
- R9: Every pointer wraps from BUF_DEPTH-1 (default 63) back to 0.
- R10: In the interrupt byte, bit0 is the enable and takes the written value. Bit1 is pending: it is set by `ctl_set_b2h_atn` and cleared by a host write of 1 to it. `host_irq` is high exactly when both bits are 1.
- R11: A host write to offset 2 with bit7 = 1 drives `ctl_hw_reset` high for exactly the next cycle. Bit7 reads as 0.
- R12: When a set and a clear of the same flag arrive in the same cycle, the set wins. This holds for response attention, request attention and interrupt pending.
- R13: `ctl_set_busy` sets control bit7 and `ctl_clr_busy` clears it. Both are visible on `ctl_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe; steps the response pointer at offset 1 |
| host_addr | input | 2 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the addressed register |
| host_irq | output | 1 | Interrupt to the host |
| ctl_set_b2h_atn | input | 1 | Controller posts a response |
| ctl_set_sms_atn | input | 1 | Controller sets SMS attention |
| ctl_set_oem0 | input | 1 | Controller sets the OEM flag |
| ctl_clr_h2b_atn | input | 1 | Controller consumes the request |
| ctl_set_busy | input | 1 | Controller busy set |
| ctl_clr_busy | input | 1 | Controller busy clear |
| ctl_ptr_clr | input | 1 | Clears the controller-side pointers |
| ctl_req_rd_en | input | 1 | Steps the request read pointer |
| ctl_req_rdata | output | 8 | Request byte at the controller read pointer |
| ctl_rsp_wr_en | input | 1 | Writes one response byte |
| ctl_rsp_wdata | input | 8 | Response byte |
| ctl_flags | output | 8 | Control byte as seen by the controller |
| ctl_hw_reset | output | 1 | One-cycle controller reset request |

## Verification
The assertions assume that every controller input is a single-cycle pulse and that each host access comes as one strobe per cycle. They also assume that the controller does not set and clear busy in the same cycle. The bench drives all inputs at the falling edge and holds each strobe for exactly one cycle, with an idle cycle between accesses. Set-against-clear collisions are applied only deliberately, to check which side takes priority.

// File: rtl/bt_mbox_pkg.sv
package bt_mbox_pkg;

    typedef enum logic [1:0] {
        OFS_CTRL = 2'd0,
        OFS_DATA = 2'd1,
        OFS_IRQ  = 2'd2,
        OFS_NONE = 2'd3
    } reg_ofs_e;

    // control byte bit positions (host software decodes these)
    localparam int CB_CLR_WR = 0;
    localparam int CB_CLR_RD = 1;
    localparam int CB_H2B    = 2;
    localparam int CB_B2H    = 3;
    localparam int CB_SMS    = 4;
    localparam int CB_OEM0   = 5;
    localparam int CB_HBUSY  = 6;
    localparam int CB_BBUSY  = 7;

    // interrupt byte bit positions
    localparam int IB_EN    = 0;
    localparam int IB_PEND  = 1;
    localparam int IB_HWRST = 7;

    localparam int DW = 8;

    typedef struct packed {
        logic b_busy;
        logic h_busy;
        logic oem0;
        logic sms_atn;
        logic b2h_atn;
        logic h2b_atn;
    } flags_t;

    typedef struct packed {
        logic          wr;
        reg_ofs_e      ofs;
        logic [DW-1:0] data;
    } host_wr_t;

    typedef struct packed {
        logic set_b2h;
        logic set_sms;
        logic set_oem0;
        logic clr_h2b;
        logic set_busy;
        logic clr_busy;
    } ctl_cmd_t;

    function automatic logic [DW-1:0] pack_ctrl(flags_t f);
        return {f.b_busy, f.h_busy, f.oem0, f.sms_atn, f.b2h_atn, f.h2b_atn, 2'b00};
    endfunction

    function automatic logic wr_bit(host_wr_t w, reg_ofs_e o, int b);
        return w.wr && (w.ofs == o) && w.data[b];
    endfunction

    // set has priority over clear
    function automatic logic next_flag(logic cur, logic set, logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction

endpackage

// File: rtl/bt_mbox_buffer.sv
module bt_mbox_buffer
    import bt_mbox_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_clr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en,
    input  logic          rd_clr,
    output logic [DW-1:0] rdata
);
    localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || wr_clr)  wr_ptr <= '0;
        else if (wr_en)     wr_ptr <= step(wr_ptr);
    end

    always_ff @(posedge clk) begin
        if (rst || rd_clr)  rd_ptr <= '0;
        else if (rd_en)     rd_ptr <= step(rd_ptr);
    end

    assign rdata = mem[rd_ptr];

    p_wptr_clear_r6: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> wr_ptr == '0);
    p_rptr_clear_r6: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> rd_ptr == '0);
    p_wptr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_clr && wr_ptr != LAST) |=> wr_ptr == $past(wr_ptr) + 1'b1);
    p_rptr_step_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_clr && rd_ptr != LAST) |=> rd_ptr == $past(rd_ptr) + 1'b1);
    p_wptr_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_clr && wr_ptr == LAST) |=> wr_ptr == '0);
    p_rptr_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_clr && rd_ptr == LAST) |=> rd_ptr == '0);

endmodule

// File: rtl/bt_mbox_flags.sv
module bt_mbox_flags
    import bt_mbox_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  host_wr_t hw,
    input  ctl_cmd_t cmd,
    output flags_t   flags,
    output logic     clr_wr_ptr,
    output logic     clr_rd_ptr
);
    flags_t flags_d;
    logic hit_h2b, hit_b2h, hit_sms, hit_oem0, hit_hbusy;

    always_comb begin
        hit_h2b    = wr_bit(hw, OFS_CTRL, CB_H2B);
        hit_b2h    = wr_bit(hw, OFS_CTRL, CB_B2H);
        hit_sms    = wr_bit(hw, OFS_CTRL, CB_SMS);
        hit_oem0   = wr_bit(hw, OFS_CTRL, CB_OEM0);
        hit_hbusy  = wr_bit(hw, OFS_CTRL, CB_HBUSY);
        clr_wr_ptr = wr_bit(hw, OFS_CTRL, CB_CLR_WR);
        clr_rd_ptr = wr_bit(hw, OFS_CTRL, CB_CLR_RD);
    end

    always_comb begin
        flags_d         = flags;
        flags_d.h_busy  = flags.h_busy ^ hit_hbusy;
        flags_d.b2h_atn = next_flag(flags.b2h_atn, cmd.set_b2h, hit_b2h);
        flags_d.sms_atn = next_flag(flags.sms_atn, cmd.set_sms, hit_sms);
        flags_d.oem0    = next_flag(flags.oem0, cmd.set_oem0, hit_oem0);
        flags_d.h2b_atn = next_flag(flags.h2b_atn, hit_h2b, cmd.clr_h2b);
        flags_d.b_busy  = next_flag(flags.b_busy, cmd.set_busy, cmd.clr_busy);
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flags_d;
    end

    p_hbusy_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        hit_hbusy |=> flags.h_busy != $past(flags.h_busy));
    p_hbusy_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !hit_hbusy |=> $stable(flags.h_busy));
    p_b2h_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (hit_b2h && !cmd.set_b2h) |=> !flags.b2h_atn);
    p_bbusy_host_r4: assert property (@(posedge clk) disable iff (rst)
        (!cmd.set_busy && !cmd.clr_busy) |=> $stable(flags.b_busy));
    p_h2b_set_r5: assert property (@(posedge clk) disable iff (rst)
        hit_h2b |=> flags.h2b_atn);
    p_h2b_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (flags.h2b_atn && !cmd.clr_h2b) |=> flags.h2b_atn);
    p_b2h_setwins_r12: assert property (@(posedge clk) disable iff (rst)
        cmd.set_b2h |=> flags.b2h_atn);
    p_busy_set_r13: assert property (@(posedge clk) disable iff (rst)
        cmd.set_busy |=> flags.b_busy);

endmodule

// File: rtl/bt_mbox_irq.sv
module bt_mbox_irq
    import bt_mbox_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  host_wr_t hw,
    input  logic     set_pend,
    output logic     irq_en,
    output logic     irq_pend,
    output logic     hw_rst,
    output logic     host_irq
);
    logic wr_irq, hit_pend, hit_hwrst;

    always_comb begin
        wr_irq    = hw.wr && (hw.ofs == OFS_IRQ);
        hit_pend  = wr_bit(hw, OFS_IRQ, IB_PEND);
        hit_hwrst = wr_bit(hw, OFS_IRQ, IB_HWRST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en   <= 1'b0;
            irq_pend <= 1'b0;
            hw_rst   <= 1'b0;
        end else begin
            if (wr_irq) irq_en <= hw.data[IB_EN];
            irq_pend <= next_flag(irq_pend, set_pend, hit_pend);
            hw_rst   <= hit_hwrst;
        end
    end

    assign host_irq = irq_en & irq_pend;

    p_pend_set_r10: assert property (@(posedge clk) disable iff (rst)
        set_pend |=> irq_pend);
    p_pend_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (hit_pend && !set_pend) |=> !irq_pend);
    p_hwrst_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        hit_hwrst |=> hw_rst);
    p_hwrst_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !hit_hwrst |=> !hw_rst);

endmodule

// File: rtl/bt_mbox_regs.sv
module bt_mbox_regs
    import bt_mbox_pkg::*;
#(
    parameter int BUF_DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr_en,
    input  logic       host_rd_en,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       host_irq,
    input  logic       ctl_set_b2h_atn,
    input  logic       ctl_set_sms_atn,
    input  logic       ctl_set_oem0,
    input  logic       ctl_clr_h2b_atn,
    input  logic       ctl_set_busy,
    input  logic       ctl_clr_busy,
    input  logic       ctl_ptr_clr,
    input  logic       ctl_req_rd_en,
    output logic [7:0] ctl_req_rdata,
    input  logic       ctl_rsp_wr_en,
    input  logic [7:0] ctl_rsp_wdata,
    output logic [7:0] ctl_flags,
    output logic       ctl_hw_reset
);
    localparam int N_DIR = 2;   // 0: request (host->ctl), 1: response (ctl->host)
    localparam int D_REQ = 0;
    localparam int D_RSP = 1;

    host_wr_t hw;
    ctl_cmd_t cmd;
    flags_t   flags;
    logic     clr_wr_ptr, clr_rd_ptr;
    logic     irq_en, irq_pend;
    reg_ofs_e ofs;

    logic [N_DIR-1:0]         b_wr, b_wclr, b_rd, b_rclr;
    logic [N_DIR-1:0][DW-1:0] b_wdata, b_rdata;

    always_comb begin
        ofs          = reg_ofs_e'(host_addr);
        hw.wr        = host_wr_en;
        hw.ofs       = ofs;
        hw.data      = host_wdata;
        cmd.set_b2h  = ctl_set_b2h_atn;
        cmd.set_sms  = ctl_set_sms_atn;
        cmd.set_oem0 = ctl_set_oem0;
        cmd.clr_h2b  = ctl_clr_h2b_atn;
        cmd.set_busy = ctl_set_busy;
        cmd.clr_busy = ctl_clr_busy;
    end

    bt_mbox_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .hw         (hw),
        .cmd        (cmd),
        .flags      (flags),
        .clr_wr_ptr (clr_wr_ptr),
        .clr_rd_ptr (clr_rd_ptr)
    );

    bt_mbox_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .hw       (hw),
        .set_pend (ctl_set_b2h_atn),
        .irq_en   (irq_en),
        .irq_pend (irq_pend),
        .hw_rst   (ctl_hw_reset),
        .host_irq (host_irq)
    );

    always_comb begin
        b_wr[D_REQ]    = host_wr_en && (ofs == OFS_DATA);
        b_wclr[D_REQ]  = clr_wr_ptr;
        b_wdata[D_REQ] = host_wdata;
        b_rd[D_REQ]    = ctl_req_rd_en;
        b_rclr[D_REQ]  = ctl_ptr_clr;
        b_wr[D_RSP]    = ctl_rsp_wr_en;
        b_wclr[D_RSP]  = ctl_ptr_clr;
        b_wdata[D_RSP] = ctl_rsp_wdata;
        b_rd[D_RSP]    = host_rd_en && (ofs == OFS_DATA);
        b_rclr[D_RSP]  = clr_rd_ptr;
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_buf
        bt_mbox_buffer #(.DEPTH(BUF_DEPTH)) u_buf (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (b_wr[d]),
            .wr_clr (b_wclr[d]),
            .wdata  (b_wdata[d]),
            .rd_en  (b_rd[d]),
            .rd_clr (b_rclr[d]),
            .rdata  (b_rdata[d])
        );
    end

    assign ctl_req_rdata = b_rdata[D_REQ];
    assign ctl_flags     = pack_ctrl(flags);

    always_comb begin
        unique case (ofs)
            OFS_CTRL: host_rdata = pack_ctrl(flags);
            OFS_DATA: host_rdata = b_rdata[D_RSP];
            OFS_IRQ:  host_rdata = {6'b0, irq_pend, irq_en};
            default:  host_rdata = '0;
        endcase
    end

    p_ptrbits_zero_r2: assert property (@(posedge clk) disable iff (rst)
        ofs == OFS_CTRL |-> host_rdata[1:0] == 2'b00);
    p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> (irq_en && irq_pend));

endmodule

// File: tb/bt_mbox_regs_tb.sv
`timescale 1ns/1ps
module bt_mbox_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr_en = 0, host_rd_en = 0;
    logic [1:0] host_addr = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       host_irq;
    logic       ctl_set_b2h_atn = 0, ctl_set_sms_atn = 0, ctl_set_oem0 = 0;
    logic       ctl_clr_h2b_atn = 0, ctl_set_busy = 0, ctl_clr_busy = 0;
    logic       ctl_ptr_clr = 0, ctl_req_rd_en = 0, ctl_rsp_wr_en = 0;
    logic [7:0] ctl_rsp_wdata = 0;
    logic [7:0] ctl_req_rdata, ctl_flags;
    logic       ctl_hw_reset;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] rd;

    always #2.5 clk = ~clk;

    bt_mbox_regs dut_i (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic host_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr_en = 1;
        @(negedge clk);
        host_wr_en = 0;
    endtask

    task automatic host_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd_en = 1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd_en = 0;
    endtask

    task automatic peek(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    // 0 b2h, 1 sms, 2 oem0, 3 clr h2b, 4 set busy, 5 clr busy, 6 ptr clr
    task automatic ctl_pulse(int sel);
        @(negedge clk);
        case (sel)
            0: ctl_set_b2h_atn = 1;
            1: ctl_set_sms_atn = 1;
            2: ctl_set_oem0    = 1;
            3: ctl_clr_h2b_atn = 1;
            4: ctl_set_busy    = 1;
            5: ctl_clr_busy    = 1;
            default: ctl_ptr_clr = 1;
        endcase
        @(negedge clk);
        ctl_set_b2h_atn = 0; ctl_set_sms_atn = 0; ctl_set_oem0 = 0;
        ctl_clr_h2b_atn = 0; ctl_set_busy = 0; ctl_clr_busy = 0; ctl_ptr_clr = 0;
    endtask

    task automatic ctl_read(output logic [7:0] d);
        @(negedge clk);
        ctl_req_rd_en = 1;
        #1 d = ctl_req_rdata;
        @(negedge clk);
        ctl_req_rd_en = 0;
    endtask

    task automatic ctl_write(logic [7:0] d);
        @(negedge clk);
        ctl_rsp_wdata = d; ctl_rsp_wr_en = 1;
        @(negedge clk);
        ctl_rsp_wr_en = 0;
    endtask

    task automatic t_reset();
        peek(2'd0, rd); check("R1 ctrl", rd, 8'h00);
        peek(2'd2, rd); check("R1 irq reg", rd, 8'h00);
        check("R1 host_irq", {7'b0, host_irq}, 8'h00);
        check("R1 ctl_flags", ctl_flags, 8'h00);
        check("R1 hw_reset", {7'b0, ctl_hw_reset}, 8'h00);
    endtask

    task automatic t_offsets();
        ctl_pulse(4);
        peek(2'd0, rd); check("R2 ctrl at 0", rd, 8'h80);
        peek(2'd3, rd); check("R2 offset 3", rd, 8'h00);
        host_write(2'd2, 8'h01);
        peek(2'd2, rd); check("R2 irq at 2", rd, 8'h01);
        host_write(2'd2, 8'h00);
        ctl_pulse(5);
    endtask

    task automatic t_hbusy();
        host_write(2'd0, 8'h40); peek(2'd0, rd); check("R3 toggle on", rd, 8'h40);
        host_write(2'd0, 8'h00); peek(2'd0, rd); check("R3 zero holds", rd, 8'h40);
        host_write(2'd0, 8'h40); peek(2'd0, rd); check("R3 toggle off", rd, 8'h00);
    endtask

    task automatic t_w1c();
        ctl_pulse(0); ctl_pulse(1); ctl_pulse(2);
        peek(2'd0, rd); check("R4 all set", rd, 8'h38);
        host_write(2'd0, 8'h08); peek(2'd0, rd); check("R4 clear b2h", rd, 8'h30);
        host_write(2'd0, 8'h00); peek(2'd0, rd); check("R4 zeros", rd, 8'h30);
        host_write(2'd0, 8'h30); peek(2'd0, rd); check("R4 clear sms oem", rd, 8'h00);
        ctl_pulse(4);
        host_write(2'd0, 8'h80); peek(2'd0, rd); check("R4 busy untouched", rd, 8'h80);
        ctl_pulse(5);
        host_write(2'd2, 8'h02);
    endtask

    task automatic t_h2b();
        host_write(2'd0, 8'h04); peek(2'd0, rd); check("R5 set", rd, 8'h04);
        host_write(2'd0, 8'h00); peek(2'd0, rd); check("R5 zero", rd, 8'h04);
        check("R5 ctl view", ctl_flags, 8'h04);
        ctl_pulse(3); peek(2'd0, rd); check("R5 ctl clear", rd, 8'h00);
    endtask

    task automatic t_request();
        host_write(2'd0, 8'h01);
        host_write(2'd1, 8'h11); host_write(2'd1, 8'h22); host_write(2'd1, 8'h33);
        ctl_pulse(6);
        ctl_read(rd); check("R7 byte0", rd, 8'h11);
        ctl_read(rd); check("R7 byte1", rd, 8'h22);
        ctl_read(rd); check("R7 byte2", rd, 8'h33);
    endtask

    task automatic t_response();
        ctl_pulse(6);
        ctl_write(8'hA0); ctl_write(8'hA1); ctl_write(8'hA2);
        host_write(2'd0, 8'h02);
        host_read(2'd1, rd); check("R8 byte0", rd, 8'hA0);
        host_read(2'd1, rd); check("R8 byte1", rd, 8'hA1);
        host_write(2'd0, 8'h03);
        peek(2'd0, rd); check("R6 strobe bits read 0", rd, 8'h00);
        host_read(2'd1, rd); check("R6 rd ptr cleared", rd, 8'hA0);
        host_read(2'd1, rd); check("R8 byte1 again", rd, 8'hA1);
        host_read(2'd1, rd); check("R8 byte2", rd, 8'hA2);
    endtask

    task automatic t_wrap();
        host_write(2'd0, 8'h01);
        for (int i = 0; i < 64; i++) host_write(2'd1, 8'(i));
        host_write(2'd1, 8'hEE);
        ctl_pulse(6);
        ctl_read(rd); check("R9 wrapped byte0", rd, 8'hEE);
        ctl_read(rd); check("R9 byte1 kept", rd, 8'h01);
    endtask

    task automatic t_irq();
        host_write(2'd2, 8'h01);
        ctl_pulse(0);
        check("R10 irq raised", {7'b0, host_irq}, 8'h01);
        peek(2'd2, rd); check("R10 reg", rd, 8'h03);
        host_write(2'd2, 8'h03);
        check("R10 irq cleared", {7'b0, host_irq}, 8'h00);
        peek(2'd2, rd); check("R10 reg after clear", rd, 8'h01);
        host_write(2'd2, 8'h00);
        ctl_pulse(0);
        check("R10 masked", {7'b0, host_irq}, 8'h00);
        peek(2'd2, rd); check("R10 pending masked", rd, 8'h02);
        host_write(2'd2, 8'h01);
        check("R10 enable late", {7'b0, host_irq}, 8'h01);
        host_write(2'd2, 8'h02);
        peek(2'd2, rd); check("R10 all clear", rd, 8'h00);
        host_write(2'd0, 8'h08);
    endtask

    task automatic t_hwrst();
        host_write(2'd2, 8'h80);
        check("R11 strobe high", {7'b0, ctl_hw_reset}, 8'h01);
        @(negedge clk);
        check("R11 strobe one cycle", {7'b0, ctl_hw_reset}, 8'h00);
        peek(2'd2, rd); check("R11 reads 0", rd, 8'h00);
    endtask

    task automatic t_setwins();
        @(negedge clk);
        ctl_set_b2h_atn = 1; host_addr = 2'd0; host_wdata = 8'h08; host_wr_en = 1;
        @(negedge clk);
        ctl_set_b2h_atn = 0; host_wr_en = 0;
        peek(2'd0, rd); check("R12 b2h set wins", rd, 8'h08);
        peek(2'd2, rd); check("R12 pending set", rd, 8'h02);
        @(negedge clk);
        ctl_set_b2h_atn = 1; host_addr = 2'd2; host_wdata = 8'h02; host_wr_en = 1;
        @(negedge clk);
        ctl_set_b2h_atn = 0; host_wr_en = 0;
        peek(2'd2, rd); check("R12 pending set wins", rd, 8'h02);
        host_write(2'd0, 8'h08);
        @(negedge clk);
        ctl_clr_h2b_atn = 1; host_addr = 2'd0; host_wdata = 8'h04; host_wr_en = 1;
        @(negedge clk);
        ctl_clr_h2b_atn = 0; host_wr_en = 0;
        peek(2'd0, rd); check("R12 h2b set wins", rd, 8'h04);
        ctl_pulse(3);
        host_write(2'd2, 8'h02);
    endtask

    task automatic t_busy();
        ctl_pulse(4); @(negedge clk); check("R13 busy set", ctl_flags, 8'h80);
        ctl_pulse(5); @(negedge clk); check("R13 busy clear", ctl_flags, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_offsets();
        t_hbusy();
        t_w1c();
        t_h2b();
        t_request();
        t_response();
        t_wrap();
        t_irq();
        t_hwrst();
        t_setwins();
        t_busy();
        report();
    end
endmodule